// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the interrupt control register of a DMA unit with up to seven channels. It holds a few plain configuration bits, an enable for each channel, a master enable, and a force bit that raises the interrupt on its own. It also holds a completion flag for each channel and an indicator that shows a request has already gone out. Software writes the enables and clears flags by writing ones to them. The DMA engine reports each finished transfer as a one-cycle pulse on that channel's completion input.

After every update the block checks its interrupt condition. The condition is true when the master enable is on and any completion flag is set, or when the force bit is set. When the condition becomes true while the sent indicator is clear, the block sends one single-cycle request pulse to the system interrupt controller, where it sets status bit 3. The sent indicator always follows the condition, so the block raises no second request until the condition has been false at least once.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A write to the register takes bits [5:0], bit 15 (force), bits [22:16] (channel enables 0..6) and bit 23 (master enable) from the written data. Bits [14:6] always read as zero.
- R2: Completion flags sit at bits [30:24], one per channel. Writing 1 to a flag clears it and writing 0 leaves it unchanged.
- R3: A pulse on `done_i[n]` sets flag bit 24+n only when enable bit 16+n is set. When the same cycle also holds a write, the newly written enable gates the pulse, and the pulse wins over a clear of that flag.
- R4: The interrupt condition is (bit 23 AND any of bits [30:24]) OR bit 15. Flags that are set while the master enable is off raise nothing until the master enable is turned on.
- R5: `irq_o` is high for exactly one cycle, the cycle after the edge at which an update makes the condition true while bit 31 (sent) was clear. Bit 31 reads 1 whenever the condition holds.
- R6: While bit 31 is set, more completions and writes that keep the condition true raise no further pulse.
- R7: An update that leaves the condition false clears bit 31. A later update that makes the condition true again raises a new pulse.
- R8: Writes take effect only when `wr_en` is high and `addr` equals the register offset 0x0F4. A write to any other address changes nothing.
- R9: A synchronous reset clears the whole register and holds `irq_o` low, even while writes and completion pulses are applied.
- R10: The value written to bit 31 has no effect. The sent indicator depends only on the condition.
- R11: Reads on `rd_data` return the full 32-bit register, flags and sent indicator included, right after the edge that updates it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (12) | Write address, matched against 0x0F4 |
| wr_data | input | 32 | Write data |
| done_i | input | NUM_CH (7) | Per-channel transfer completion pulses |
| rd_data | output | 32 | Current register contents |
| irq_o | output | 1 | One-cycle request to set system interrupt status bit 3 |

## Verification
The hardest state to reach is the re-arm path. The condition must go false through a write, either a flag clear or the master enable turned off, and then turn true again through a completion or an enable, and the sent indicator must block pulses in between. The stimulus walks through these transitions in order. It also lines up a write that clears a flag in the same cycle as a completion on that channel, and it sets flags while the master enable is off. A long mixed phase of random writes and completions then follows, and a reference model runs in step with it.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W      = 32;
  localparam int LOW_W      = 6;
  localparam int FORCE_BIT  = 15;
  localparam int ENA_LSB    = 16;
  localparam int MASTER_BIT = 23;
  localparam int FLAG_LSB   = 24;
  localparam int SENT_BIT   = 31;
  localparam int MAX_CH     = 7;
endpackage

// File: rtl/dma_irq_cfg.sv
module dma_irq_cfg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [LOW_W-1:0]  low_q,
  output logic              force_q,
  output logic              master_q,
  output logic [NUM_CH-1:0] ena_q,
  output logic              force_n,
  output logic              master_n,
  output logic [NUM_CH-1:0] ena_n
);
  // values seen by this cycle's update (write-through)
  always_comb begin
    force_n  = wr ? wr_data[FORCE_BIT]           : force_q;
    master_n = wr ? wr_data[MASTER_BIT]          : master_q;
    ena_n    = wr ? wr_data[ENA_LSB +: NUM_CH]   : ena_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q    <= '0;
      force_q  <= 1'b0;
      master_q <= 1'b0;
      ena_q    <= '0;
    end else if (wr) begin
      low_q    <= wr_data[LOW_W-1:0];
      force_q  <= force_n;
      master_q <= master_n;
      ena_q    <= ena_n;
    end
  end

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(ena_q) && $stable(master_q) && $stable(force_q) && $stable(low_q));
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] ena_n,
  output logic [NUM_CH-1:0] flags_q,
  output logic [NUM_CH-1:0] flags_n
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    // completion wins over a same-cycle clear
    assign flags_n[n] = (flags_q[n] & ~(wr & clr_bits[n])) | (done_i[n] & ena_n[n]);

    always_ff @(posedge clk) begin
      if (rst) flags_q[n] <= 1'b0;
      else     flags_q[n] <= flags_n[n];
    end

    // R3
    flag_set_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flags_q[n]) |-> $past(done_i[n] && ena_n[n]));

    // R2
    flag_clr_src_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flags_q[n]) |-> $past(wr && clr_bits[n]));
  end
endmodule

// File: rtl/dma_irq_edge.sv
module dma_irq_edge
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_n,
  input  logic              force_n,
  input  logic [NUM_CH-1:0] flags_n,
  output logic              sent_q,
  output logic              irq_q
);
  logic cond;
  assign cond = (master_n & (|flags_n)) | force_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sent_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sent_q <= cond;
      irq_q  <= cond & ~sent_q;
    end
  end

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R6
  no_resend_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sent_q) |-> !irq_q);

  // R5
  irq_marks_sent_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> sent_q);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h0F4,
  parameter int              NUM_CH     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NUM_CH-1:0] done_i,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_o
);
  logic              wr;
  logic [LOW_W-1:0]  low_q;
  logic              force_q, master_q, force_n, master_n;
  logic [NUM_CH-1:0] ena_q, ena_n, flags_q, flags_n;
  logic              sent_q;

  assign wr = wr_en && (addr == REG_OFFSET);

  dma_irq_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk(clk), .rst(rst), .wr(wr), .wr_data(wr_data),
    .low_q(low_q), .force_q(force_q), .master_q(master_q), .ena_q(ena_q),
    .force_n(force_n), .master_n(master_n), .ena_n(ena_n)
  );

  dma_irq_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst(rst), .wr(wr),
    .clr_bits(wr_data[FLAG_LSB +: NUM_CH]),
    .done_i(done_i), .ena_n(ena_n),
    .flags_q(flags_q), .flags_n(flags_n)
  );

  dma_irq_edge #(.NUM_CH(NUM_CH)) u_edge (
    .clk(clk), .rst(rst), .master_n(master_n), .force_n(force_n),
    .flags_n(flags_n), .sent_q(sent_q), .irq_q(irq_o)
  );

  always_comb begin
    rd_data                        = '0;
    rd_data[LOW_W-1:0]             = low_q;
    rd_data[FORCE_BIT]             = force_q;
    rd_data[ENA_LSB +: NUM_CH]     = ena_q;
    rd_data[MASTER_BIT]            = master_q;
    rd_data[FLAG_LSB +: NUM_CH]    = flags_q;
    rd_data[SENT_BIT]              = sent_q;
  end

  // R7
  sent_tracks_cond_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[SENT_BIT] == ((rd_data[MASTER_BIT] && (|rd_data[FLAG_LSB +: NUM_CH])) || rd_data[FORCE_BIT]));

  // R8
  miss_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr && done_i == '0) |=> $stable(rd_data));
endmodule

// File: tb/dma_irq_ctrl_tb.sv
module dma_irq_ctrl_tb;
  localparam int NUM_CH = 7;
  localparam logic [11:0] OFF = 12'h0F4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  done_i = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  always #4 clk = ~clk;

  dma_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .done_i(done_i), .rd_data(rd_data), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] rd;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] m = '0;
  bit          done_flag = 0;

  task automatic check(string tag, logic [31:0] ard, logic airq, logic [31:0] erd, logic eirq);
    checks++;
    if (ard !== erd || airq !== eirq) begin
      errors++;
      $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b", tag, ard, airq, erd, eirq);
    end
  endtask

  // driver: drive at negedge, push expectation for the next edge
  task automatic op(bit w, logic [11:0] a, logic [31:0] d, logic [6:0] dn, string tag);
    logic [31:0] nx;
    logic        cond, ei;
    exp_t        e;
    @(negedge clk);
    wr_en = w; addr = a; wr_data = d; done_i = dn;
    if (w && a == OFF) nx = (d & 32'h00FF803F) | (m & ~d & 32'h7F000000);
    else               nx = m & 32'h7FFFFFFF;
    for (int n = 0; n < NUM_CH; n++)
      if (dn[n] && nx[16+n]) nx[24+n] = 1'b1;
    cond = (nx[23] && (|nx[30:24])) || nx[15];
    ei = cond && !m[31];
    if (cond) nx[31] = 1'b1;
    m = nx;
    e.rd = nx; e.irq = ei; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: sample 2 ns after the edge that consumed the oldest item
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, rd_data, irq_o, e.rd, e.irq);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: rd=%h irq=%b expected completion", rd_data, irq_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset with activity applied
    @(negedge clk);
    wr_en = 1; addr = OFF; wr_data = 32'hFFFF_FFFF; done_i = 7'h7F;
    repeat (3) begin
      @(negedge clk);
      check("R9 reset", rd_data, irq_o, 32'h0, 1'b0);
    end
    rst = 0; wr_en = 0; done_i = 0;

    op(0, OFF, 32'h0, 7'h00, "R9 idle after reset");
    op(1, OFF, 32'hFFFF_FFFF, 7'h00, "R1 R5 R11 full write force");
    op(0, OFF, 32'h0, 7'h00, "R6 hold no resend");
    op(1, OFF, 32'h0, 7'h00, "R7 clear condition");
    op(1, OFF, 32'h00FF_0000, 7'h00, "R1 enables master");
    op(0, OFF, 32'h0, 7'h04, "R3 R5 ch2 completion");
    op(0, OFF, 32'h0, 7'h20, "R6 ch5 no resend");
    op(1, OFF, 32'h04FF_0000, 7'h00, "R2 clear flag26 only");
    op(1, OFF, 32'h20FF_0000, 7'h00, "R7 clear last flag");
    op(0, OFF, 32'h0, 7'h10, "R7 rearm ch4");
    op(1, OFF, 32'h7F81_0000, 7'h01, "R3 done beats clear");
    op(1, OFF, 32'h7F01_0000, 7'h00, "R4 master off");
    op(0, OFF, 32'h0, 7'h7F, "R3 R4 gated and masked");
    op(1, OFF, 32'h0081_0000, 7'h00, "R4 master on raises");
    op(1, 12'h0F0, 32'h0, 7'h00, "R8 other address");
    op(0, OFF, 32'h0, 7'h00, "R8 wr_en low");
    op(1, OFF, 32'hFF00_0000, 7'h00, "R10 bit31 written");
    op(1, OFF, 32'h0000_7FFF, 7'h00, "R1 bits 14:6 zero");
    op(1, OFF, 32'h0000_0000, 7'h00, "R7 drop force");

    // mixed phase
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      logic [11:0] a;
      d = $urandom;
      d[15] = ($urandom_range(0, 7) == 0);
      a = ($urandom_range(0, 9) == 0) ? 12'h0F8 : OFF;
      op($urandom_range(0, 2) == 0, a, d, 7'($urandom) & 7'($urandom), "R3 R5 R6 R7 mixed");
    end
    op(0, OFF, 32'h0, 7'h00, "R11 final");

    @(negedge clk);
    wr_en = 0; done_i = 0;
    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule